// File: doc/BRIEF.md
# Mode-0 programmable parallel port

This block is a three-port parallel I/O peripheral on a synchronous CPU bus. It offers only the simple static input/output mode. Each of the three 8-bit ports, A, B and C, has an output latch, a direction setting and an input path from its pins. Port C is split into two nibbles, and each nibble has its own direction. The CPU selects one of four registers with a two-bit address while chip select is low. Writes are sampled on the rising clock edge when the write strobe is high. Reads return data combinationally while the read strobe is high.

The register at address 3 is a write-only control register, and bit 7 of each word written to it selects what the word does. A word with bit 7 set programs the port directions. A word with bit 7 clear sets or clears a single bit of the port C latch. The parameter `REDUCED` builds a lower-compatibility variant. In that variant port B is always an input, port C is always an output, and a direction write does not clear the latches.

Top module: `ppio_mode0`

## Requirements
- R1: Chip select is active low. While `cs_n` is high, a write strobe changes no latch and no direction, and `rdata` reads 0. While `cs_n` is low, `addr` picks the register: 0 is port A, 1 is port B, 2 is port C and 3 is the control register.
- R2: A read at address 3 returns 8'hFF and never the control contents.
- R3: A control word with bit 7 = 1 sets the directions. Bit 4 = 1 makes port A an input. Bit 3 = 1 makes the upper nibble of port C an input. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes the lower nibble of port C an input. Bits 6:5 and bit 2 are ignored. An output-enable bit is 1 exactly where that bit is set as output, and the two nibbles of `pc_oe` are each uniform.
- R4: With `REDUCED` = 0, every direction-set word clears the latches of ports A, B and C to zero.
- R5: A control word with bit 7 = 0 writes bit 0 of the word into port C latch bit number word[3:1]. No other latch bit changes, and bits 6:4 are ignored.
- R6: Reading a data port returns the pin value on each bit set as input and the latch value on each bit set as output. Port C is treated nibble by nibble.
- R7: A write to a data port updates its latch even when that port is set as input. `p*_out` always shows the latch, and `p*_oe` tells where the pins are driven.
- R8: With `REDUCED` = 1, `pb_oe` is always 0 and `pc_oe` is always 8'hFF, whatever control word is written. Port A still follows bit 4, and a direction-set word leaves all latches unchanged.
- R9: After reset all latches are zero and every port is an input. In the reduced variant port C is the exception and stays an output.
- R10: A write takes effect at the first rising clock edge at which the strobe is sampled high, and its result is visible on the outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Register select |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| wdata | input | 8 | Write data from CPU |
| rdata | output | 8 | Read data to CPU, 0 when not reading |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enable per bit |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enable per bit |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C drive enable per bit |

## Verification
The bench builds two copies side by side on one shared bus, one with `REDUCED` = 0 and one with `REDUCED` = 1. Every one of the 128 direction-set words goes to both copies against preloaded latches. This shows the clear-versus-keep difference and the forced directions of the reduced copy on the same stimulus. All 16 direction combinations are read back with several pin patterns, which covers the per-nibble merge on port C. Every bit index and value of the single-bit write is applied, with changing filler in the ignored bits.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int HW = DW / 2;

  localparam logic [1:0] ADR_A   = 2'd0;
  localparam logic [1:0] ADR_B   = 2'd1;
  localparam logic [1:0] ADR_C   = 2'd2;
  localparam logic [1:0] ADR_CTL = 2'd3;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};

  // Input mask: 1 where a bit reads from the pins
  function automatic logic [DW-1:0] in_mask(input logic hi_in, input logic lo_in);
    return {{HW{hi_in}}, {HW{lo_in}}};
  endfunction

  function automatic logic [DW-1:0] merge_rd(input logic [DW-1:0] pin,
                                             input logic [DW-1:0] lat,
                                             input logic [DW-1:0] msk);
    return (pin & msk) | (lat & ~msk);
  endfunction

  function automatic logic [DW-1:0] bit_op(input logic [DW-1:0] lat,
                                           input logic [IW-1:0] idx,
                                           input logic          val);
    logic [DW-1:0] r;
    r      = lat;
    r[idx] = val;
    return r;
  endfunction
endpackage

// File: rtl/ppio_busdec.sv
module ppio_busdec (
  input  logic       cs_n,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic       ctl_b7,
  output logic [2:0] ev_wr_port,
  output logic       ev_mode_set,
  output logic       ev_bit_op,
  output logic       rd_sel
);
  logic wr_sel;
  assign wr_sel = ~cs_n & wr;
  assign rd_sel = ~cs_n & rd;

  always_comb begin
    ev_wr_port = '0;
    if (wr_sel && addr != ppio_pkg::ADR_CTL) ev_wr_port[addr] = 1'b1;
  end

  assign ev_mode_set = wr_sel && (addr == ppio_pkg::ADR_CTL) &&  ctl_b7;
  assign ev_bit_op   = wr_sel && (addr == ppio_pkg::ADR_CTL) && !ctl_b7;
endmodule

// File: rtl/ppio_dirreg.sv
module ppio_dirreg #(
  parameter bit REDUCED = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  ppio_pkg::dir_t nd,
  output ppio_pkg::dir_t dir
);
  generate
    if (REDUCED) begin : g_red
      logic a_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    a_q <= 1'b1;
        else if (load) a_q <= nd.a_in;
      end
      assign dir = '{a_in: a_q, b_in: 1'b1, cu_in: 1'b0, cl_in: 1'b0};
    end else begin : g_full
      ppio_pkg::dir_t d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    d_q <= ppio_pkg::DIR_RESET;
        else if (load) d_q <= nd;
      end
      assign dir = d_q;
    end
  endgenerate
endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          bop,
  input  logic [IW-1:0] bop_idx,
  input  logic          bop_val,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= ld_data;
    else if (bop) q <= ppio_pkg::bit_op(q, bop_idx, bop_val);
  end
endmodule

// File: rtl/ppio_mode0.sv
module ppio_mode0 #(
  parameter bit REDUCED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [1:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  import ppio_pkg::*;
  localparam int NP = 3;

  logic [NP-1:0]         ev_wr_port;
  logic                  ev_mode_set;
  logic                  ev_bit_op;
  logic                  ev_clear;
  logic                  rd_sel;
  dir_t                  nd;
  dir_t                  dir;
  logic [NP-1:0][DW-1:0] lat_q;
  logic [NP-1:0][DW-1:0] pin_v;
  logic [NP-1:0][DW-1:0] msk;

  ppio_busdec u_dec (
    .cs_n(cs_n), .addr(addr), .wr(wr), .rd(rd), .ctl_b7(wdata[7]),
    .ev_wr_port(ev_wr_port), .ev_mode_set(ev_mode_set),
    .ev_bit_op(ev_bit_op), .rd_sel(rd_sel)
  );

  assign nd = '{a_in: wdata[4], b_in: wdata[1], cu_in: wdata[3], cl_in: wdata[0]};

  ppio_dirreg #(.REDUCED(REDUCED)) u_dir (
    .clk(clk), .rst_n(rst_n), .load(ev_mode_set), .nd(nd), .dir(dir)
  );

  assign ev_clear = REDUCED ? 1'b0 : ev_mode_set;

  assign pin_v = {pc_in, pb_in, pa_in};
  assign msk[0] = in_mask(dir.a_in,  dir.a_in);
  assign msk[1] = in_mask(dir.b_in,  dir.b_in);
  assign msk[2] = in_mask(dir.cu_in, dir.cl_in);

  generate
    for (genvar i = 0; i < NP; i++) begin : g_port
      ppio_latch #(.DW(DW)) u_lat (
        .clk(clk), .rst_n(rst_n), .clr(ev_clear),
        .ld(ev_wr_port[i]), .ld_data(wdata),
        .bop((i == NP-1) && ev_bit_op),
        .bop_idx(wdata[IW:1]), .bop_val(wdata[0]),
        .q(lat_q[i])
      );
    end
  endgenerate

  assign pa_out = lat_q[0];
  assign pb_out = lat_q[1];
  assign pc_out = lat_q[2];
  assign pa_oe  = ~msk[0];
  assign pb_oe  = ~msk[1];
  assign pc_oe  = ~msk[2];

  always_comb begin
    rdata = '0;
    if (rd_sel) begin
      if (addr == ADR_CTL) rdata = '1;
      else                 rdata = merge_rd(pin_v[addr], lat_q[addr], msk[addr]);
    end
  end
endmodule

// File: rtl/ppio_mode0_chk.sv
module ppio_mode0_chk #(
  parameter bit REDUCED = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [1:0] addr,
  input logic       rd,
  input logic       ev_mode_set,
  input logic       ev_bit_op,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe
);
  a_r1_deselect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r1_deselect_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (rdata == 8'h00));

  a_r2_ctl_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rd && addr == 2'd3) |-> (rdata == 8'hFF));

  a_r3_nibble_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

  a_r4_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!REDUCED && ev_mode_set) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit_op |=> ($countones(pc_out ^ $past(pc_out)) <= 1 &&
                   $stable(pa_out) && $stable(pb_out)));

  a_r8_fixed_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    REDUCED |-> (pb_oe == 8'h00 && pc_oe == 8'hFF));

  a_r8_modeset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (REDUCED && ev_mode_set) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
endmodule

bind ppio_mode0 ppio_mode0_chk #(.REDUCED(REDUCED)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd(rd),
  .ev_mode_set(ev_mode_set), .ev_bit_op(ev_bit_op), .rdata(rdata),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/ppio_mode0_test.sv
module ppio_mode0_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;

  logic [7:0] f_rdata, f_pa_out, f_pa_oe, f_pb_out, f_pb_oe, f_pc_out, f_pc_oe;
  logic [7:0] r_rdata, r_pa_out, r_pa_oe, r_pb_out, r_pb_oe, r_pc_out, r_pc_oe;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  ppio_mode0 #(.REDUCED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(f_rdata),
    .pa_in(pa_in), .pa_out(f_pa_out), .pa_oe(f_pa_oe),
    .pb_in(pb_in), .pb_out(f_pb_out), .pb_oe(f_pb_oe),
    .pc_in(pc_in), .pc_out(f_pc_out), .pc_oe(f_pc_oe));

  ppio_mode0 #(.REDUCED(1'b1)) uut_red (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(r_rdata),
    .pa_in(pa_in), .pa_out(r_pa_out), .pa_oe(r_pa_oe),
    .pb_in(pb_in), .pb_out(r_pb_out), .pb_oe(r_pb_oe),
    .pc_in(pc_in), .pc_out(r_pc_out), .pc_oe(r_pc_oe));

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Write strobe for one cycle; returns at the next negedge with results visible (R10)
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] fv, output logic [7:0] rv);
    cs_n = 1'b0; addr = a; rd = 1'b1;
    #1;
    fv = f_rdata; rv = r_rdata;
    rd = 1'b0; cs_n = 1'b1;
    #1;
  endtask

  function automatic logic [7:0] full8(input logic in_bit);
    return in_bit ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic [7:0] mix(input logic [7:0] pin, input logic [7:0] lat, input logic [7:0] oe);
    return (lat & oe) | (pin & ~oe);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] fv, rv, w, p, e, ea, eb, ec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9", "full pa_out", f_pa_out, 8'h00);
    chk("R9", "full pb_out", f_pb_out, 8'h00);
    chk("R9", "full pc_out", f_pc_out, 8'h00);
    chk("R9", "full pa_oe",  f_pa_oe,  8'h00);
    chk("R9", "full pb_oe",  f_pb_oe,  8'h00);
    chk("R9", "full pc_oe",  f_pc_oe,  8'h00);
    chk("R9", "red pc_oe",   r_pc_oe,  8'hFF);
    chk("R9", "red pc_out",  r_pc_out, 8'h00);

    // R1 deselected write and read
    cs_n = 1'b1; addr = 2'd2; wdata = 8'hFF; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R1", "deselected write pc", r_pc_out, 8'h00);
    rd = 1'b1; addr = 2'd3; #1;
    chk("R1", "deselected rdata", f_rdata, 8'h00);
    rd = 1'b0;

    // R1 address map, R7 latch loads while input
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd1, 8'h22);
    bus_wr(2'd2, 8'h33);
    chk("R1", "map pa_out", f_pa_out, 8'h11);
    chk("R7", "map pb_out while input", f_pb_out, 8'h22);
    chk("R1", "map pc_out", f_pc_out, 8'h33);
    chk("R7", "oe still off", f_pa_oe | f_pb_oe | f_pc_oe, 8'h00);

    // R2 control reads ones
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd3, fv, rv);
    chk("R2", "full ctl read", fv, 8'hFF);
    chk("R2", "red ctl read",  rv, 8'hFF);

    // R3 R4 R8: all direction-set words against preloaded latches
    for (int i = 0; i < 128; i++) begin
      w = 8'h80 | 8'(i);
      bus_wr(2'd0, 8'h5A);
      bus_wr(2'd1, 8'hA5);
      bus_wr(2'd2, 8'h3C);
      bus_wr(2'd3, w);
      chk("R3", "full pa_oe", f_pa_oe, full8(w[4]));
      chk("R3", "full pb_oe", f_pb_oe, full8(w[1]));
      chk("R3", "full pc_oe", f_pc_oe, {full8(w[3])[7:4], full8(w[0])[3:0]});
      chk("R4", "full clear", f_pa_out | f_pb_out | f_pc_out, 8'h00);
      chk("R8", "red pa_oe", r_pa_oe, full8(w[4]));
      chk("R8", "red pb_oe", r_pb_oe, 8'h00);
      chk("R8", "red pc_oe", r_pc_oe, 8'hFF);
      chk("R8", "red keep pa", r_pa_out, 8'h5A);
      chk("R8", "red keep pb", r_pb_out, 8'hA5);
      chk("R8", "red keep pc", r_pc_out, 8'h3C);
    end

    // R5 single-bit writes, filler in ignored bits 6:4
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h77);
    for (int idx = 0; idx < 8; idx++) begin
      for (int v = 0; v < 2; v++) begin
        p = 8'hA5 ^ 8'(idx * 17);
        bus_wr(2'd2, p);
        w = {1'b0, 3'(idx + v), 3'(idx), 1'(v)};
        bus_wr(2'd3, w);
        e = p;
        e[idx] = 1'(v);
        chk("R5", "full pc bit op", f_pc_out, e);
        chk("R5", "red pc bit op",  r_pc_out, e);
        chk("R5", "pa untouched",   f_pa_out, 8'h77);
      end
    end

    // R6 R7 read merge across all direction combinations
    for (int d = 0; d < 16; d++) begin
      w = {3'b100, 1'(d >> 3), 1'(d >> 2), 1'b0, 1'(d >> 1), 1'(d)};
      bus_wr(2'd3, w);
      bus_wr(2'd0, 8'hC3);
      bus_wr(2'd1, 8'h96);
      bus_wr(2'd2, 8'h5A);
      for (int k = 0; k < 3; k++) begin
        pa_in = 8'h0F ^ 8'(k * 85); pb_in = 8'hF0 ^ 8'(k * 51); pc_in = 8'h33 ^ 8'(k * 29);
        ea = full8(w[4]); eb = full8(w[1]); ec = {full8(w[3])[7:4], full8(w[0])[3:0]};
        bus_rd(2'd0, fv, rv);
        chk("R6", "full read A", fv, mix(pa_in, 8'hC3, ea));
        chk("R6", "red read A",  rv, mix(pa_in, 8'hC3, ea));
        bus_rd(2'd1, fv, rv);
        chk("R6", "full read B", fv, mix(pb_in, 8'h96, eb));
        chk("R8", "red read B input", rv, pb_in);
        bus_rd(2'd2, fv, rv);
        chk("R6", "full read C", fv, mix(pc_in, 8'h5A, ec));
        chk("R8", "red read C output", rv, 8'h5A);
      end
      chk("R7", "latch A after write", f_pa_out, 8'hC3);
      chk("R7", "latch B after write", f_pb_out, 8'h96);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule